// File: doc/BRIEF.md
# Double-Precision to 32-bit Integer Converter

This block turns a packed 64-bit IEEE-754 binary64 value into a 32-bit integer. A per-operation select picks the signed or the unsigned form. The rounding mode comes from a 2-bit input, and a truncate input forces rounding toward zero whatever that input holds. With the integer come three flags: invalid, for results that cannot be represented, saturated results and NaN inputs; inexact, for results that dropped nonzero fraction bits; and input-denormal, for subnormal operands.

The datapath is combinational and one register stage follows it. A conversion offered with `in_valid` high appears on the outputs one clock later, with `out_valid` high. The outputs keep their last result while no new operation arrives. The signed and unsigned forms differ in three places: saturation bounds, NaN results and the handling of magnitudes below one. A pipeline uses the block where it needs a float-to-integer instruction and merges the flags into its own exception state.

Top module: `f2i_conv`

## Requirements
- R1: `out_valid` rises exactly one clock after a cycle with `in_valid` high and is low otherwise. Synchronous active-high reset clears `out_valid`, `out_int` and all flags. The result registers hold their value in cycles without `in_valid`.
- R2: A zero input of either sign gives 0 with no flag raised.
- R3: A subnormal input (exponent field 0, nonzero fraction) raises the denormal flag. It is then handled as a nonzero value below one, so inexact is also raised.
- R4: A NaN input in signed form gives 0 with invalid. In unsigned form a NaN counts as positive whatever its sign bit, and gives 0xFFFFFFFF with invalid.
- R5: When the biased exponent is at least 1055 (this includes infinities), the result saturates and only invalid is raised. Signed: 0x7FFFFFFF, or 0x80000000 for negative inputs. Unsigned: 0xFFFFFFFF, or 0 for negative inputs.
- R6: Rounding mode encoding is 0 = nearest with ties to even, 1 = toward +infinity, 2 = toward -infinity, 3 = toward zero. In nearest mode a fraction above one half rounds away from zero, a fraction below one half rounds toward zero, and an exact half goes to the even integer.
- R7: The directed modes add one to the magnitude when the fraction is nonzero and (mode is toward +infinity) XOR (input is negative). Toward zero never adds.
- R8: When the result is not saturated, a nonzero discarded fraction raises inexact. Exact in-range values raise no flag.
- R9: In signed form, if the rounded magnitude exceeds 0x7FFFFFFF (or 0x80000000 for a negative input), the result saturates to that bound with invalid and without inexact. Otherwise the magnitude is negated for negative inputs.
- R10: In unsigned form, a rounding carry out of 0xFFFFFFFF keeps 0xFFFFFFFF and raises invalid. A negative input whose rounded magnitude is nonzero gives 0 with invalid. A negative non-NaN input always gives 0.
- R11: A nonzero value with biased exponent below 1022 gives 0 with inexact. Exceptions: toward +infinity with a positive input gives 1. Toward -infinity with a negative input gives 0xFFFFFFFF (-1) in signed form, or 0 with invalid added in unsigned form.
- R12: With `in_trunc` high, `in_rmode` has no effect and every conversion rounds toward zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation present this cycle |
| in_data | input | 64 | Packed binary64 operand |
| in_signed | input | 1 | 1 = signed result, 0 = unsigned result |
| in_trunc | input | 1 | 1 = force rounding toward zero |
| in_rmode | input | 2 | Rounding mode (0 nearest, 1 up, 2 down, 3 toward zero) |
| out_valid | output | 1 | Result present this cycle |
| out_int | output | 32 | Converted integer |
| out_invalid | output | 1 | Invalid-operation flag |
| out_inexact | output | 1 | Inexact flag |
| out_denorm | output | 1 | Input-denormal flag |

## Verification
The properties compare each result with the operand captured one clock earlier. They therefore take for granted that `in_data`, `in_signed`, `in_trunc` and `in_rmode` carry known values in every cycle where `in_valid` is high, and that all four arrive in the same cycle as the strobe. Every rounding-mode code is legal, so no property restricts `in_rmode`. The stimulus changes the inputs only on falling edges. It holds them at defined values from time zero, including the reset cycles. It raises `in_valid` only with a complete operand, both in single operations and in back-to-back pairs.

// File: rtl/f2i_pkg.sv
`timescale 1ns/1ps
package f2i_pkg;

    localparam int DBL_W = 64;
    localparam int EXP_W = 11;
    localparam int MAN_W = 52;
    localparam int BIAS  = 1023;
    localparam int ALN_W = 64;                   // aligned significand width
    localparam int PAD_W = ALN_W - 1 - MAN_W;    // zero padding below fraction
    localparam int SH_W  = $clog2(ALN_W) + 1;    // shift amount width

    typedef enum logic [1:0] {
        RM_NEAREST = 2'd0,
        RM_UP      = 2'd1,
        RM_DOWN    = 2'd2,
        RM_ZERO    = 2'd3
    } rmode_e;

    typedef struct packed {
        logic             sign;
        logic [EXP_W-1:0] exp;
        logic [MAN_W-1:0] man;
    } dbl_t;

    typedef struct packed {
        logic nan;
        logic big;     // saturating exponent range (includes inf/NaN)
        logic mid;     // value needs shifting and rounding
        logic zero;
        logic denorm;
    } cls_t;

    function automatic rmode_e eff_mode(logic trunc, logic [1:0] rm);
        return trunc ? RM_ZERO : rmode_e'(rm);
    endfunction

    // Amount added to the left-justified remainder; a carry out bumps the result.
    function automatic logic [ALN_W-1:0] round_incr(rmode_e m, logic neg, logic lsb);
        logic [ALN_W-1:0] half;
        half = {1'b1, {(ALN_W-1){1'b0}}};
        case (m)
            RM_NEAREST: return lsb ? half : half - ALN_W'(1);
            RM_ZERO:    return '0;
            default:    return ((m == RM_UP) ^ neg) ? '1 : '0;
        endcase
    endfunction

endpackage

// File: rtl/f2i_classify.sv
`timescale 1ns/1ps
module f2i_classify
    import f2i_pkg::*;
#(
    parameter int INT_W = 32
) (
    input  logic [DBL_W-1:0] raw,
    output dbl_t             fld,
    output cls_t             cls
);
    localparam logic [EXP_W-1:0] BIG_EXP = EXP_W'(BIAS + INT_W);
    localparam logic [EXP_W-1:0] MID_EXP = EXP_W'(BIAS - 1);

    logic exp_all1;
    logic man_nz;

    always_comb begin
        fld        = dbl_t'(raw);
        exp_all1   = &fld.exp;
        man_nz     = |fld.man;
        cls.nan    = exp_all1 & man_nz;
        cls.big    = fld.exp >= BIG_EXP;
        cls.mid    = !cls.big && (fld.exp >= MID_EXP);
        cls.zero   = (fld.exp == '0) && !man_nz;
        cls.denorm = (fld.exp == '0) && man_nz;
    end

endmodule

// File: rtl/f2i_align.sv
`timescale 1ns/1ps
module f2i_align
    import f2i_pkg::*;
#(
    parameter int INT_W = 32
) (
    input  logic [EXP_W-1:0] exp,
    input  logic [MAN_W-1:0] man,
    output logic [INT_W-1:0] int_part,
    output logic [ALN_W-1:0] rem
);
    logic [ALN_W-1:0] aligned;
    logic [SH_W-1:0]  sh;

    // Hidden one at the MSB; right shift of (BIAS+ALN_W-1-exp) leaves the integer.
    always_comb begin
        aligned  = {1'b1, man, {PAD_W{1'b0}}};
        sh       = SH_W'(EXP_W'(BIAS + ALN_W - 1) - exp);
        int_part = INT_W'(aligned >> sh);
        rem      = aligned << (SH_W'(ALN_W) - sh);
    end

endmodule

// File: rtl/f2i_round.sv
`timescale 1ns/1ps
module f2i_round
    import f2i_pkg::*;
#(
    parameter int INT_W = 32
) (
    input  cls_t             cls,
    input  logic             sign,
    input  logic             is_signed,
    input  rmode_e           mode,
    input  logic [INT_W-1:0] int_part,
    input  logic [ALN_W-1:0] rem,
    output logic [INT_W-1:0] value,
    output logic             invalid,
    output logic             inexact,
    output logic             denorm
);
    localparam logic [INT_W-1:0] UMAX = {INT_W{1'b1}};
    localparam logic [INT_W-1:0] SMAX = {1'b0, {(INT_W-1){1'b1}}};
    localparam logic [INT_W-1:0] SMIN = {1'b1, {(INT_W-1){1'b0}}};

    logic             neg;
    logic [ALN_W-1:0] incr;
    logic             carry;
    logic             bump;
    logic [INT_W:0]   mag;
    logic [INT_W:0]   lim;

    always_comb begin
        neg     = sign & ~cls.nan;
        incr    = round_incr(mode, neg, int_part[0]);
        carry   = ALN_W'(rem + incr) < rem;
        bump    = carry && (int_part != UMAX);
        mag     = {1'b0, int_part} + (INT_W+1)'(bump);
        lim     = {1'b0, SMAX} + (INT_W+1)'(neg);
        value   = '0;
        invalid = 1'b0;
        inexact = 1'b0;
        denorm  = cls.denorm;

        if (cls.nan && is_signed) begin
            invalid = 1'b1;
        end else if (cls.nan || cls.big) begin
            invalid = 1'b1;
            if (is_signed) value = neg ? SMIN : SMAX;
            else           value = neg ? '0 : UMAX;
        end else if (cls.mid) begin
            if (is_signed) begin
                if (mag > lim) begin
                    mag     = lim;
                    invalid = 1'b1;
                end else if (|rem) begin
                    inexact = 1'b1;
                end
                value = neg ? INT_W'(-mag) : INT_W'(mag);
            end else begin
                value = int_part + INT_W'(bump);
                if (carry && !bump) invalid = 1'b1;
                if (neg && (value != '0)) begin
                    value   = '0;
                    invalid = 1'b1;
                end else if (|rem) begin
                    inexact = 1'b1;
                end
            end
        end else if (!cls.zero) begin
            inexact = 1'b1;
            if (mode == RM_UP && !sign) begin
                value = INT_W'(1);
            end else if (mode == RM_DOWN && sign) begin
                if (is_signed) value = UMAX;
                else           invalid = 1'b1;
            end
        end
    end

endmodule

// File: rtl/f2i_conv.sv
`timescale 1ns/1ps
module f2i_conv
    import f2i_pkg::*;
#(
    parameter int INT_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic [DBL_W-1:0] in_data,
    input  logic             in_signed,
    input  logic             in_trunc,
    input  logic [1:0]       in_rmode,
    output logic             out_valid,
    output logic [INT_W-1:0] out_int,
    output logic             out_invalid,
    output logic             out_inexact,
    output logic             out_denorm
);
    dbl_t             fld;
    cls_t             cls;
    rmode_e           mode;
    logic [INT_W-1:0] int_part;
    logic [ALN_W-1:0] rem;
    logic [INT_W-1:0] nxt_int;
    logic             nxt_inv;
    logic             nxt_inx;
    logic             nxt_den;

    assign mode = eff_mode(in_trunc, in_rmode);

    f2i_classify #(.INT_W(INT_W)) u_cls (
        .raw (in_data),
        .fld (fld),
        .cls (cls)
    );

    f2i_align #(.INT_W(INT_W)) u_aln (
        .exp      (fld.exp),
        .man      (fld.man),
        .int_part (int_part),
        .rem      (rem)
    );

    f2i_round #(.INT_W(INT_W)) u_rnd (
        .cls       (cls),
        .sign      (fld.sign),
        .is_signed (in_signed),
        .mode      (mode),
        .int_part  (int_part),
        .rem       (rem),
        .value     (nxt_int),
        .invalid   (nxt_inv),
        .inexact   (nxt_inx),
        .denorm    (nxt_den)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid   <= 1'b0;
            out_int     <= '0;
            out_invalid <= 1'b0;
            out_inexact <= 1'b0;
            out_denorm  <= 1'b0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                out_int     <= nxt_int;
                out_invalid <= nxt_inv;
                out_inexact <= nxt_inx;
                out_denorm  <= nxt_den;
            end
        end
    end

    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);                                          // R1
    AST_VALID_IDLE: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);                                        // R1
    AST_ZERO_QUIET: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_data[DBL_W-2:0] == '0) |=>
        (out_int == '0 && !out_invalid && !out_inexact && !out_denorm)); // R2
    AST_DENORM_INEXACT: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_denorm) |-> out_inexact);                       // R3
    AST_SIGNED_NAN: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_signed && (&in_data[DBL_W-2 -: EXP_W]) && (|in_data[MAN_W-1:0]))
        |=> (out_int == '0 && out_invalid));                              // R4
    AST_UNSIGNED_NEG: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !in_signed && in_data[DBL_W-1] && !(&in_data[DBL_W-2 -: EXP_W]))
        |=> (out_int == '0));                                             // R10

endmodule

// File: tb/test_f2i_conv.sv
`timescale 1ns/1ps
module test_f2i_conv;

    typedef struct packed {
        logic [63:0] d;
        logic        sgn;
        logic        trn;
        logic [1:0]  rm;
        logic [31:0] val;
        logic        inv;
        logic        inx;
        logic        den;
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 47;
    // rm: 0 nearest, 1 up, 2 down, 3 toward zero
    localparam vec_t VECS [NV] = '{
        '{64'h0000000000000000,1'b1,1'b0,2'd0,32'h00000000,1'b0,1'b0,1'b0,8'd2},  // R2
        '{64'h8000000000000000,1'b0,1'b0,2'd0,32'h00000000,1'b0,1'b0,1'b0,8'd2},  // R2
        '{64'h3FF8000000000000,1'b1,1'b0,2'd0,32'h00000002,1'b0,1'b1,1'b0,8'd6},  // R6 1.5
        '{64'h4004000000000000,1'b1,1'b0,2'd0,32'h00000002,1'b0,1'b1,1'b0,8'd6},  // R6 2.5
        '{64'hC004000000000000,1'b1,1'b0,2'd0,32'hFFFFFFFE,1'b0,1'b1,1'b0,8'd6},  // R6 -2.5
        '{64'h3FFC000000000000,1'b1,1'b0,2'd0,32'h00000002,1'b0,1'b1,1'b0,8'd6},  // R6 1.75
        '{64'h3FF4000000000000,1'b1,1'b0,2'd0,32'h00000001,1'b0,1'b1,1'b0,8'd6},  // R6 1.25
        '{64'h3FE0000000000000,1'b1,1'b0,2'd0,32'h00000000,1'b0,1'b1,1'b0,8'd6},  // R6 0.5
        '{64'h3FF8000000000000,1'b1,1'b0,2'd1,32'h00000002,1'b0,1'b1,1'b0,8'd7},  // R7
        '{64'hBFF8000000000000,1'b1,1'b0,2'd1,32'hFFFFFFFF,1'b0,1'b1,1'b0,8'd7},  // R7
        '{64'hBFF8000000000000,1'b1,1'b0,2'd2,32'hFFFFFFFE,1'b0,1'b1,1'b0,8'd7},  // R7
        '{64'h3FF8000000000000,1'b1,1'b0,2'd3,32'h00000001,1'b0,1'b1,1'b0,8'd7},  // R7
        '{64'h401C000000000000,1'b1,1'b0,2'd1,32'h00000007,1'b0,1'b0,1'b0,8'd8},  // R8 7.0
        '{64'h40F0000000000000,1'b0,1'b0,2'd0,32'h00010000,1'b0,1'b0,1'b0,8'd8},  // R8
        '{64'h41E0000000000000,1'b0,1'b0,2'd0,32'h80000000,1'b0,1'b0,1'b0,8'd8},  // R8
        '{64'h3FF8000000000000,1'b1,1'b1,2'd0,32'h00000001,1'b0,1'b1,1'b0,8'd12}, // R12
        '{64'hBFF8000000000000,1'b1,1'b1,2'd2,32'hFFFFFFFF,1'b0,1'b1,1'b0,8'd12}, // R12
        '{64'h3FF8000000000000,1'b0,1'b1,2'd1,32'h00000001,1'b0,1'b1,1'b0,8'd12}, // R12
        '{64'h7FF8000000000000,1'b1,1'b0,2'd0,32'h00000000,1'b1,1'b0,1'b0,8'd4},  // R4
        '{64'h7FF8000000000000,1'b0,1'b0,2'd0,32'hFFFFFFFF,1'b1,1'b0,1'b0,8'd4},  // R4
        '{64'hFFF8000000000000,1'b0,1'b0,2'd0,32'hFFFFFFFF,1'b1,1'b0,1'b0,8'd4},  // R4
        '{64'h7FF0000000000000,1'b1,1'b0,2'd0,32'h7FFFFFFF,1'b1,1'b0,1'b0,8'd5},  // R5
        '{64'hFFF0000000000000,1'b1,1'b0,2'd0,32'h80000000,1'b1,1'b0,1'b0,8'd5},  // R5
        '{64'hFFF0000000000000,1'b0,1'b0,2'd0,32'h00000000,1'b1,1'b0,1'b0,8'd5},  // R5
        '{64'h41F0000000000000,1'b0,1'b0,2'd0,32'hFFFFFFFF,1'b1,1'b0,1'b0,8'd5},  // R5
        '{64'h41F0000000000000,1'b1,1'b0,2'd0,32'h7FFFFFFF,1'b1,1'b0,1'b0,8'd5},  // R5
        '{64'h41E0000000000000,1'b1,1'b0,2'd0,32'h7FFFFFFF,1'b1,1'b0,1'b0,8'd9},  // R9
        '{64'hC1E0000000000000,1'b1,1'b0,2'd0,32'h80000000,1'b0,1'b0,1'b0,8'd9},  // R9
        '{64'h41DFFFFFFFE00000,1'b1,1'b0,2'd0,32'h7FFFFFFF,1'b1,1'b0,1'b0,8'd9},  // R9
        '{64'h41DFFFFFFFE00000,1'b1,1'b0,2'd3,32'h7FFFFFFF,1'b0,1'b1,1'b0,8'd8},  // R8
        '{64'hC1E0000000100000,1'b1,1'b0,2'd0,32'h80000000,1'b0,1'b1,1'b0,8'd9},  // R9
        '{64'hC1E0000000100000,1'b1,1'b0,2'd2,32'h80000000,1'b1,1'b0,1'b0,8'd9},  // R9
        '{64'h41EFFFFFFFF00000,1'b0,1'b0,2'd0,32'hFFFFFFFF,1'b1,1'b1,1'b0,8'd10}, // R10
        '{64'h41EFFFFFFFF00000,1'b0,1'b0,2'd3,32'hFFFFFFFF,1'b0,1'b1,1'b0,8'd8},  // R8
        '{64'hBFE8000000000000,1'b0,1'b0,2'd0,32'h00000000,1'b1,1'b0,1'b0,8'd10}, // R10
        '{64'hBFE8000000000000,1'b0,1'b0,2'd3,32'h00000000,1'b0,1'b1,1'b0,8'd10}, // R10
        '{64'hBFF0000000000000,1'b0,1'b0,2'd0,32'h00000000,1'b1,1'b0,1'b0,8'd10}, // R10
        '{64'h3FD0000000000000,1'b1,1'b0,2'd0,32'h00000000,1'b0,1'b1,1'b0,8'd11}, // R11
        '{64'h3FD0000000000000,1'b1,1'b0,2'd1,32'h00000001,1'b0,1'b1,1'b0,8'd11}, // R11
        '{64'hBFD0000000000000,1'b1,1'b0,2'd2,32'hFFFFFFFF,1'b0,1'b1,1'b0,8'd11}, // R11
        '{64'hBFD0000000000000,1'b0,1'b0,2'd2,32'h00000000,1'b1,1'b1,1'b0,8'd11}, // R11
        '{64'hBFD0000000000000,1'b1,1'b0,2'd1,32'h00000000,1'b0,1'b1,1'b0,8'd11}, // R11
        '{64'h0000000000000001,1'b1,1'b0,2'd0,32'h00000000,1'b0,1'b1,1'b1,8'd3},  // R3
        '{64'h0000000000000001,1'b0,1'b0,2'd1,32'h00000001,1'b0,1'b1,1'b1,8'd3},  // R3
        '{64'h8000000000000001,1'b0,1'b0,2'd2,32'h00000000,1'b1,1'b1,1'b1,8'd3},  // R3
        '{64'h8000000000000001,1'b1,1'b0,2'd2,32'hFFFFFFFF,1'b0,1'b1,1'b1,8'd3},  // R3
        '{64'h3FD0000000000000,1'b1,1'b1,2'd1,32'h00000000,1'b0,1'b1,1'b0,8'd12}  // R12
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [63:0] in_data = '0;
    logic        in_signed = 1'b0;
    logic        in_trunc = 1'b0;
    logic [1:0]  in_rmode = '0;
    logic        out_valid;
    logic [31:0] out_int;
    logic        out_invalid;
    logic        out_inexact;
    logic        out_denorm;

    int  n_checks = 0;
    int  n_fails  = 0;
    bit  done     = 1'b0;

    always #2.5 clk = ~clk;

    f2i_conv i_f2i_conv (
        .clk         (clk),
        .rst         (rst),
        .in_valid    (in_valid),
        .in_data     (in_data),
        .in_signed   (in_signed),
        .in_trunc    (in_trunc),
        .in_rmode    (in_rmode),
        .out_valid   (out_valid),
        .out_int     (out_int),
        .out_invalid (out_invalid),
        .out_inexact (out_inexact),
        .out_denorm  (out_denorm)
    );

    task automatic check(input bit ok, input int req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL R%0d %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic apply(input vec_t v, input int idx);
        logic [34:0] act;
        logic [34:0] exp;
        @(negedge clk);
        in_data   = v.d;
        in_signed = v.sgn;
        in_trunc  = v.trn;
        in_rmode  = v.rm;
        in_valid  = 1'b1;
        @(negedge clk);
        in_valid  = 1'b0;
        act = {out_int, out_invalid, out_inexact, out_denorm};
        exp = {v.val, v.inv, v.inx, v.den};
        check(out_valid && act == exp, int'(v.req),
              $sformatf("vector %0d {int,inv,inx,den}", idx), 64'(act), 64'(exp));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check({out_valid, out_int, out_invalid, out_inexact, out_denorm} == '0, 1,
              "reset state", {28'd0, out_valid, out_int, out_invalid, out_inexact, out_denorm}, '0);
        rst = 1'b0;
        @(negedge clk);
        check(!out_valid, 1, "idle out_valid", 64'(out_valid), 64'd0); // R1

        for (int i = 0; i < NV; i++) apply(VECS[i], i);

        // R1: single-cycle strobe, latency one, hold while idle
        @(negedge clk);
        in_data = 64'h3FF0000000000000; in_signed = 1'b1; in_trunc = 1'b0; in_rmode = 2'd0;
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        in_data  = 64'h4014000000000000;
        check(out_valid && out_int == 32'd1, 1, "latency one", {31'd0, out_valid, out_int}, {31'd1, 32'd1});
        @(negedge clk);
        check(!out_valid && out_int == 32'd1, 1, "hold when idle", {31'd0, out_valid, out_int}, {31'd0, 32'd1});

        // R1: back-to-back operations
        in_data = 64'h4014000000000000; in_valid = 1'b1;       // 5.0
        @(negedge clk);
        check(out_valid && out_int == 32'd5, 1, "back-to-back first", {31'd0, out_valid, out_int}, {31'd1, 32'd5});
        in_data = 64'hC024000000000000; in_signed = 1'b1;      // -10.0
        @(negedge clk);
        in_valid = 1'b0;
        check(out_valid && out_int == 32'hFFFFFFF6, 1, "back-to-back second", {31'd0, out_valid, out_int}, {31'd1, 32'hFFFFFFF6});
        @(negedge clk);
        check(!out_valid, 1, "strobe drops", 64'(out_valid), 64'd0);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL R1 watchdog expired: actual running expected done");
            $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
            $finish;
        end
    end

endmodule